// File: doc/BRIEF.md
# Burst Read Frame Generator

This block builds the transmit side of a burst read on a serial sensor port. The serial front end hands it each received 16-bit command word. When that word is the burst command and chip select is low, the block captures nine output registers in a single cycle. The front end then loads one 16-bit word into its shifter at each word boundary. The block supplies the words one after another with no gap, and the checksum word comes last.

The captured frame holds the following words in a fixed order: a status word, the three gyroscope axes, the three accelerometer axes, a temperature word, and one final data word. The sync-mode field chooses the final data word. When it selects scaled sync, the final word is a timestamp. In all other modes it is a sample counter. The checksum is added up as the words are handed over. If chip select rises before the frame is complete, the burst is abandoned and the block returns to idle.

Top module: `burst_frame_gen`

## Requirements
- R1: A burst starts only when `rx_valid` is high, `rx_word` equals 0x6800, `cs_n` is low and the block is idle. `busy` is then high from the next cycle. Any other word (for example 0x6801), or the command while `cs_n` is high, leaves `busy` low.
- R2: After a start, each cycle with `tx_next` high hands over the word shown on `tx_data` and moves to the next one. The order is: status, gyro X, gyro Y, gyro Z, accel X, accel Y, accel Z, temperature, final data word, checksum. The X axis is bits [15:0] of `gyro_xyz` and `accel_xyz`, Y is [31:16] and Z is [47:32].
- R3: The final data word is `time_stamp` when `sync_mode` equals 3'b010. For any other value it is `data_count`.
- R4: The checksum word is the sum, modulo 65536, of the high byte and the low byte of each of the nine data words. Each byte is added as an unsigned 8-bit value. Every new burst starts the sum from zero.
- R5: All nine data words and the final-word choice are fixed in the cycle the command is accepted. Changes on the data inputs or on `sync_mode` after that cycle do not alter the frame.
- R6: If `cs_n` is high while `busy` is high, `busy` is low in the next cycle and `done` does not pulse. The next command then streams a complete, fresh frame.
- R7: When `tx_next` takes the checksum word, `done` is high for exactly one cycle on the next cycle and `busy` goes low at the same time.
- R8: `tx_next` may be high on consecutive cycles, so one word can be handed over per clock with no stall between words.
- R9: `tx_data` is 0 while idle. A command word that arrives during a burst is ignored and the sequence continues where it was.
- R10: After a synchronous reset, `busy`, `done` and `tx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| rx_valid | input | 1 | A full 16-bit word was received |
| rx_word | input | 16 | Received word |
| tx_next | input | 1 | Front end loads `tx_data` into its shifter |
| sync_mode | input | 3 | Sync-mode field; 3'b010 is scaled sync |
| status_word | input | 16 | Live status register |
| gyro_xyz | input | 48 | Gyroscope X/Y/Z registers |
| accel_xyz | input | 48 | Accelerometer X/Y/Z registers |
| temp_word | input | 16 | Temperature register |
| data_count | input | 16 | Sample counter |
| time_stamp | input | 16 | Sync timestamp |
| tx_data | output | 16 | Word to send next |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the checksum is taken |

## Verification
The hardest case to reach from the ports is a frame that must stay intact while the live registers change. This happens when an update lands between words. The stimulus applies new values to every data input and flips `sync_mode` right after the command is accepted. The expected words still come from the values present at acceptance. A second hard case is an abort partway through a frame followed by a new command. That run checks that both the word position and the checksum start from zero again. A repeated command sent in the middle of a burst checks that the word position is not reset.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int WORD_W     = 16;
    localparam int DATA_WORDS = 9;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [DATA_WORDS-1:0] frame_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } state_t;

    function automatic word_t byte_sum(input word_t w);
        return {8'd0, w[15:8]} + {8'd0, w[7:0]};
    endfunction
endpackage

// File: rtl/burst_cmd_detect.sv
module burst_cmd_detect
    import burst_pkg::*;
#(
    parameter word_t CMD_WORD = 16'h6800
) (
    input  logic  rx_valid,
    input  word_t rx_word,
    input  logic  cs_n,
    input  logic  idle,
    output logic  start
);
    always_comb begin
        start = rx_valid && !cs_n && idle && (rx_word == CMD_WORD);
    end
endmodule

// File: rtl/burst_snapshot.sv
module burst_snapshot
    import burst_pkg::*;
#(
    parameter int          AXES        = 3,
    parameter logic [2:0]  SCALED_MODE = 3'b010
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic [2:0]             sync_mode,
    input  word_t                  status_word,
    input  logic [AXES*WORD_W-1:0] gyro_xyz,
    input  logic [AXES*WORD_W-1:0] accel_xyz,
    input  word_t                  temp_word,
    input  word_t                  data_count,
    input  word_t                  time_stamp,
    output frame_t                 frame
);
    localparam int GYRO_BASE  = 1;
    localparam int ACCEL_BASE = GYRO_BASE + AXES;
    localparam int TEMP_POS   = ACCEL_BASE + AXES;
    localparam int LAST_POS   = TEMP_POS + 1;

    frame_t next_frame;

    always_comb begin
        next_frame           = '0;
        next_frame[0]        = status_word;
        next_frame[TEMP_POS] = temp_word;
        next_frame[LAST_POS] = (sync_mode == SCALED_MODE) ? time_stamp : data_count;
    end

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        always_ff @(posedge clk) begin
            if (rst) begin
                frame[GYRO_BASE + a]  <= '0;
                frame[ACCEL_BASE + a] <= '0;
            end else if (capture) begin
                frame[GYRO_BASE + a]  <= gyro_xyz[a*WORD_W +: WORD_W];
                frame[ACCEL_BASE + a] <= accel_xyz[a*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame[0]        <= '0;
            frame[TEMP_POS] <= '0;
            frame[LAST_POS] <= '0;
        end else if (capture) begin
            frame[0]        <= next_frame[0];
            frame[TEMP_POS] <= next_frame[TEMP_POS];
            frame[LAST_POS] <= next_frame[LAST_POS];
        end
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(frame)); // R5
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import burst_pkg::*;
#(
    parameter int N_WORDS = DATA_WORDS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cs_n,
    input  logic   tx_next,
    input  frame_t frame,
    output word_t  tx_data,
    output logic   busy,
    output logic   done
);
    localparam int IDX_W = $clog2(N_WORDS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS);

    state_t           state;
    logic [IDX_W-1:0] idx;
    word_t            sum;
    word_t            cur_word;

    always_comb begin
        cur_word = sum;
        for (int i = 0; i < N_WORDS; i++) begin
            if (idx == IDX_W'(i)) cur_word = frame[i];
        end
    end

    assign busy    = (state == ST_STREAM);
    assign tx_data = busy ? cur_word : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            sum   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_STREAM;
                        idx   <= '0;
                        sum   <= '0;
                    end
                end
                ST_STREAM: begin
                    if (cs_n) begin
                        state <= ST_IDLE;
                    end else if (tx_next) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                            sum <= sum + byte_sum(cur_word);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= LAST_IDX)); // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (busy && cs_n) |=> (!busy && !done)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(tx_next))); // R7
    AST_SUM_FRESH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sum == '0 && idx == '0)); // R4
endmodule

// File: rtl/burst_frame_gen.sv
module burst_frame_gen
    import burst_pkg::*;
#(
    parameter logic [15:0] CMD_WORD    = 16'h6800,
    parameter logic [2:0]  SCALED_MODE = 3'b010,
    parameter int          AXES        = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rx_valid,
    input  logic [15:0]          rx_word,
    input  logic                 tx_next,
    input  logic [2:0]           sync_mode,
    input  logic [15:0]          status_word,
    input  logic [AXES*16-1:0]   gyro_xyz,
    input  logic [AXES*16-1:0]   accel_xyz,
    input  logic [15:0]          temp_word,
    input  logic [15:0]          data_count,
    input  logic [15:0]          time_stamp,
    output logic [15:0]          tx_data,
    output logic                 busy,
    output logic                 done
);
    logic   start;
    frame_t frame;

    burst_cmd_detect #(.CMD_WORD(CMD_WORD)) u_detect (
        .rx_valid (rx_valid),
        .rx_word  (rx_word),
        .cs_n     (cs_n),
        .idle     (!busy),
        .start    (start)
    );

    burst_snapshot #(.AXES(AXES), .SCALED_MODE(SCALED_MODE)) u_snap (
        .clk         (clk),
        .rst         (rst),
        .capture     (start),
        .sync_mode   (sync_mode),
        .status_word (status_word),
        .gyro_xyz    (gyro_xyz),
        .accel_xyz   (accel_xyz),
        .temp_word   (temp_word),
        .data_count  (data_count),
        .time_stamp  (time_stamp),
        .frame       (frame)
    );

    burst_sequencer #(.N_WORDS(DATA_WORDS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cs_n    (cs_n),
        .tx_next (tx_next),
        .frame   (frame),
        .tx_data (tx_data),
        .busy    (busy),
        .done    (done)
    );

    AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (!busy && cs_n) |=> !busy); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tx_data == 16'h0000)); // R9
endmodule

// File: tb/burst_frame_gen_test.sv
`timescale 1ns/1ps
module burst_frame_gen_test;
    logic        clk = 1'b0;
    logic        rst, cs_n, rx_valid, tx_next;
    logic [15:0] rx_word;
    logic [2:0]  sync_mode;
    logic [15:0] status_word, temp_word, data_count, time_stamp;
    logic [47:0] gyro_xyz, accel_xyz;
    logic [15:0] tx_data;
    logic        busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_frame_gen uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .tx_next(tx_next), .sync_mode(sync_mode), .status_word(status_word),
        .gyro_xyz(gyro_xyz), .accel_xyz(accel_xyz), .temp_word(temp_word),
        .data_count(data_count), .time_stamp(time_stamp),
        .tx_data(tx_data), .busy(busy), .done(done)
    );

    // table entry: {gap, mode[2:0], seed[15:0]}
    localparam logic [19:0] VECTORS [6] = '{
        {1'b0, 3'b000, 16'h1234},
        {1'b0, 3'b010, 16'hBEEF},
        {1'b1, 3'b001, 16'hFFFF},
        {1'b1, 3'b010, 16'h0000},
        {1'b0, 3'b101, 16'h8001},
        {1'b1, 3'b011, 16'h7A5C}
    };

    function automatic logic [15:0] wf(input logic [15:0] s, input int k);
        logic [31:0] p;
        p = s * (k * 7 + 3);
        return p[15:0] ^ (16'h1111 * k[15:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] s, input logic [2:0] m);
        sync_mode   = m;
        status_word = wf(s, 0);
        gyro_xyz    = {wf(s, 3), wf(s, 2), wf(s, 1)};
        accel_xyz   = {wf(s, 6), wf(s, 5), wf(s, 4)};
        temp_word   = wf(s, 7);
        data_count  = wf(s, 8);
        time_stamp  = wf(s, 9);
    endtask

    task automatic build_exp(input logic [15:0] s, input logic [2:0] m, output logic [15:0] e [10]);
        logic [15:0] sum;
        sum = 16'h0;
        for (int k = 0; k < 8; k++) e[k] = wf(s, k);
        e[8] = (m == 3'b010) ? wf(s, 9) : wf(s, 8);
        for (int k = 0; k < 9; k++) sum = sum + {8'h0, e[k][15:8]} + {8'h0, e[k][7:0]};
        e[9] = sum;
    endtask

    task automatic send_cmd(input logic [15:0] w);
        rx_valid = 1'b1;
        rx_word  = w;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_word  = 16'h0;
    endtask

    task automatic stream(input logic [15:0] e [10], input int first, input int last, input bit gap);
        for (int k = first; k <= last; k++) begin
            chk(tx_data == e[k], (k == 9) ? "R4 checksum" : ((k == 8) ? "R3 final word" : "R2 word order"), tx_data, e[k]);
            tx_next = 1'b1;
            @(negedge clk);
            tx_next = 1'b0;
            if (gap && k != 9) @(negedge clk);
        end
    endtask

    task automatic full_frame(input logic [15:0] s, input logic [2:0] m, input bit gap);
        logic [15:0] e [10];
        build_exp(s, m, e);
        drive(s, m);
        cs_n = 1'b0;
        @(negedge clk);
        send_cmd(16'h6800);
        chk(busy == 1'b1, "R1 start", {15'h0, busy}, 16'h1);
        drive(~s, m ^ 3'b010);  // R5 inputs change after capture
        stream(e, 0, 9, gap);
        chk(done == 1'b1 && busy == 1'b0, "R7 done pulse", {14'h0, done, busy}, 16'h2);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single", {15'h0, done}, 16'h0);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; rx_valid = 1'b0; rx_word = 16'h0; tx_next = 1'b0;
        drive(16'h0, 3'b000);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && tx_data == 16'h0, "R10 reset", tx_data, 16'h0);
        rst = 1'b0;
        @(negedge clk);

        // table walk (R2 R3 R4 R5 R7 R8)
        foreach (VECTORS[i]) full_frame(VECTORS[i][15:0], VECTORS[i][18:16], VECTORS[i][19]);

        // R1 wrong word
        cs_n = 1'b0;
        send_cmd(16'h6801);
        chk(busy == 1'b0, "R1 wrong word", {15'h0, busy}, 16'h0);
        // R1 command with cs_n high
        cs_n = 1'b1;
        send_cmd(16'h6800);
        chk(busy == 1'b0, "R1 cs high", {15'h0, busy}, 16'h0);
        chk(tx_data == 16'h0, "R9 idle zero", tx_data, 16'h0);

        // R6 abort mid-frame, then fresh frame
        begin
            logic [15:0] e [10];
            build_exp(16'h4321, 3'b000, e);
            drive(16'h4321, 3'b000);
            cs_n = 1'b0;
            send_cmd(16'h6800);
            stream(e, 0, 3, 1'b0);
            cs_n = 1'b1;
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R6 abort", {14'h0, done, busy}, 16'h0);
            chk(tx_data == 16'h0, "R6 idle after abort", tx_data, 16'h0);
        end
        full_frame(16'h5A5A, 3'b010, 1'b0);

        // R9 command during burst ignored
        begin
            logic [15:0] e [10];
            build_exp(16'h0F0F, 3'b001, e);
            drive(16'h0F0F, 3'b001);
            cs_n = 1'b0;
            send_cmd(16'h6800);
            stream(e, 0, 4, 1'b0);
            drive(16'h9999, 3'b010);
            send_cmd(16'h6800);
            chk(tx_data == e[5], "R9 repeat command ignored", tx_data, e[5]);
            stream(e, 5, 9, 1'b0);
            chk(done == 1'b1, "R9 frame completes", {15'h0, done}, 16'h1);
            cs_n = 1'b1;
            @(negedge clk);
        end

        // R10 reset in mid-burst
        cs_n = 1'b0;
        send_cmd(16'h6800);
        rst = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && tx_data == 16'h0, "R10 reset mid-burst", tx_data, 16'h0);
        rst = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule